// File: doc/BRIEF.md
# Command Stream Front End

This block walks a ring of 32-bit command words in memory, starting at a get pointer and stopping at a put pointer that the host advances. Each word is classified as a method header, a jump, a call, a return, a no-operation or an illegal word. A method header carries a register offset, an argument count and an increment mode. Each of its arguments leaves the block as one (register, value, location) triple on a valid/ready stream. Flow-control words change the get pointer. One return slot supports a single level of subroutine.

The host writes put to publish new commands and writes get to redirect the stream. A recovery pointer and a recovery return slot, both driven as inputs, define where the stream resumes after an illegal word. A two-bit status tells the host whether the front end is running, drained, parked on a no-op, or spinning on a jump to itself. Memory is read through a word port that returns data one cycle after the request.

The controller has four states:
- S_IDLE: issues the header read when get differs from put, then goes to S_DECODE.
- S_DECODE: classifies the word. A method with arguments goes to S_ARGWAIT. Every other word goes back to S_IDLE.
- S_ARGWAIT: captures the argument and goes to S_PRESENT.
- S_PRESENT: holds the triple until it is accepted. It then goes to S_ARGWAIT for the next argument, or to S_IDLE after the last one.

A host write to get forces S_IDLE from any state.

Top module: `cmdfe_top`

## Requirements
- R1: When get equals put, no memory read is issued and no triple is produced. If the status was running (code 0), it becomes empty (code 1). Status codes: 0 running, 1 empty, 2 nop-idle, 3 spinning. Reset state: get 0, put 0, status empty, no valid output, no error.
- R2: A method header is a word that matches none of the other encodings. Its argument count is bits 28:18 and its first register is the word AND 0xFFFC. Each argument produces one triple. The triple's location is the byte address of that argument (header address + 4 + 4·i). The status becomes running.
- R3: When header bit 30 is clear, the register rises by 4 per argument. When bit 30 is set, every argument goes to the first register.
- R4: If count·4+4 exceeds put−get, the count is cut to (put−get)/4−1. A count cut to 0 only advances get by 4.
- R5: Get stays fixed while a packet is in flight. Get moves to the word after the last argument only when that argument is accepted. An unaccepted triple is held unchanged.
- R6: A word with (w AND 0xE0000003)=0x20000000 is a narrow jump, and get becomes w AND 0x1FFFFFFC. A word with w[1:0]=1 is a wide jump, and get becomes w AND 0xFFFFFFFC. Both targets are truncated to the pointer width.
- R7: A word with w[1:0]=2 is a call. With the slot empty, the call stores its own address + 4 in the slot and jumps to w AND 0xFFFFFFFC. The word 0x00020000 is a return. With the slot full, the return jumps to the slot and empties it.
- R8: A call with the slot already full jumps to the slot and empties it. A return with the slot empty sets get to put.
- R9: A word with w[1:0]=3 is illegal. Get loads the recovery pointer, the slot loads the recovery slot inputs, and the error output pulses for exactly one cycle.
- R10: A word with (w AND 0xBFFF0003)=0 (other than the encodings above) is a no-op. It advances get by 4 and changes the status from running to nop-idle (code 2).
- R11: A jump whose target equals its own address sets the status to spinning (code 3). The status stays spinning until a method header is decoded.
- R12: A host write to get loads get and drops any fetched work. No further triple from the old stream follows. A triple accepted in the same cycle as the write still counts as delivered. A host write to put takes effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rd_en | output | 1 | Memory word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| put_wr | input | 1 | Host write strobe for put |
| put_data | input | AW | New put value |
| get_wr | input | 1 | Host write strobe for get |
| get_data | input | AW | New get value |
| rcv_get | input | AW | Recovery pointer used after an illegal word |
| rcv_ret_valid | input | 1 | Recovery return slot full flag |
| rcv_ret_addr | input | AW | Recovery return slot address |
| cmd_valid | output | 1 | Triple valid |
| cmd_ready | input | 1 | Downstream accepts the triple |
| cmd_reg | output | 16 | Register byte offset |
| cmd_value | output | 32 | Argument value |
| cmd_loc | output | AW | Byte address of the argument |
| get_ptr | output | AW | Current get pointer |
| fe_err | output | 1 | One-cycle pulse on an illegal word |
| fe_status | output | 2 | 0 running, 1 empty, 2 nop-idle, 3 spinning |

## Verification
A host write to get and the acceptance of a triple can fall in the same cycle. In that cycle the delivered triple must count, and the redirect must cancel the rest of the packet. The bench provokes this by raising the get write in exactly the cycle the third argument of a six-argument packet is accepted. It judges the outcome by three things: exactly three triples arrive, none follow, and get shows the written value. A behavioural walker in the bench predicts every triple, the final pointer, the status and the error count, including under random backpressure.

// File: rtl/cmdfe_pkg.sv
`timescale 1ns/1ps
package cmdfe_pkg;
    localparam int CNT_W    = 11;
    localparam int CNT_LSB  = 18;
    localparam int NINC_BIT = 30;

    localparam logic [31:0] NARROW_JMP_MASK = 32'hE000_0003;
    localparam logic [31:0] NARROW_JMP_VAL  = 32'h2000_0000;
    localparam logic [31:0] NARROW_TGT_MASK = 32'h1FFF_FFFC;
    localparam logic [31:0] WIDE_TGT_MASK   = 32'hFFFF_FFFC;
    localparam logic [31:0] RETURN_WORD     = 32'h0002_0000;
    localparam logic [31:0] NOP_MASK        = 32'hBFFF_0003;

    typedef enum logic [2:0] {
        WK_METHOD,
        WK_JUMP_NARROW,
        WK_JUMP_WIDE,
        WK_CALL,
        WK_RETURN,
        WK_NOP,
        WK_ILLEGAL
    } word_kind_e;

    typedef enum logic [1:0] {
        FS_RUNNING = 2'd0,
        FS_EMPTY   = 2'd1,
        FS_NOP     = 2'd2,
        FS_SPIN    = 2'd3
    } fe_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DECODE,
        S_ARGWAIT,
        S_PRESENT
    } fe_state_e;
endpackage

// File: rtl/cmdfe_decode.sv
`timescale 1ns/1ps
module cmdfe_decode
    import cmdfe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [31:0]      word,
    output word_kind_e       kind,
    output logic [AW-1:0]    target,
    output logic [CNT_W-1:0] count,
    output logic [15:0]      reg_ofs,
    output logic             ninc
);
    always_comb begin
        kind   = WK_METHOD;
        target = AW'(word & WIDE_TGT_MASK);
        if ((word & NARROW_JMP_MASK) == NARROW_JMP_VAL) begin
            kind   = WK_JUMP_NARROW;
            target = AW'(word & NARROW_TGT_MASK);
        end else if (word == RETURN_WORD) begin
            kind = WK_RETURN;
        end else if (word[1:0] == 2'd1) begin
            kind = WK_JUMP_WIDE;
        end else if (word[1:0] == 2'd2) begin
            kind = WK_CALL;
        end else if (word[1:0] == 2'd3) begin
            kind = WK_ILLEGAL;
        end else if ((word & NOP_MASK) == 32'd0) begin
            kind = WK_NOP;
        end
    end

    assign count   = word[CNT_LSB +: CNT_W];
    assign reg_ofs = word[15:0] & 16'hFFFC;
    assign ninc    = word[NINC_BIT];
endmodule

// File: rtl/cmdfe_clip.sv
`timescale 1ns/1ps
module cmdfe_clip #(
    parameter int AW = 16,
    parameter int CW = 11
) (
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] get_ptr,
    input  logic [AW-1:0] put_ptr,
    output logic [CW-1:0] count_eff
);
    localparam int XW = ((AW > CW + 2) ? AW : CW + 2) + 1;

    logic [AW-1:0] avail;
    logic [XW-1:0] avail_x;
    logic [XW-1:0] need;

    always_comb begin
        avail     = put_ptr - get_ptr;
        avail_x   = XW'(avail);
        need      = XW'({count, 2'b00}) + XW'(4);
        count_eff = (need > avail_x) ? CW'((avail_x >> 2) - XW'(1)) : count;
    end
endmodule

// File: rtl/cmdfe_retslot.sv
`timescale 1ns/1ps
module cmdfe_retslot #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    input  logic          load,
    input  logic          load_valid,
    input  logic [AW-1:0] load_addr,
    output logic          full,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            addr <= '0;
        end else if (load) begin
            full <= load_valid;
            addr <= load_addr;
        end else if (push) begin
            full <= 1'b1;
            addr <= push_addr;
        end else if (pop) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/cmdfe_top.sv
`timescale 1ns/1ps
module cmdfe_top
    import cmdfe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [31:0]   mem_rdata,
    input  logic          put_wr,
    input  logic [AW-1:0] put_data,
    input  logic          get_wr,
    input  logic [AW-1:0] get_data,
    input  logic [AW-1:0] rcv_get,
    input  logic          rcv_ret_valid,
    input  logic [AW-1:0] rcv_ret_addr,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [15:0]   cmd_reg,
    output logic [31:0]   cmd_value,
    output logic [AW-1:0] cmd_loc,
    output logic [AW-1:0] get_ptr,
    output logic          fe_err,
    output logic [1:0]    fe_status
);
    localparam int            CW   = CNT_W;
    localparam logic [AW-1:0] STEP = AW'(4);

    fe_state_e  state_q, state_d;
    fe_status_e status_q, status_d;

    logic [AW-1:0] get_q, get_d;
    logic [AW-1:0] put_q;
    logic [AW-1:0] ptr_q, ptr_d;
    logic [CW-1:0] rem_q, rem_d;
    logic [15:0]   reg_q, reg_d;
    logic          ninc_q, ninc_d;
    logic [31:0]   val_q, val_d;
    logic [AW-1:0] loc_q, loc_d;
    logic          valid_q, valid_d;
    logic          err_q, err_d;

    logic          rd_en;
    logic [AW-1:0] rd_addr;

    word_kind_e    kind;
    logic [AW-1:0] target;
    logic [CW-1:0] hdr_count;
    logic [CW-1:0] eff_count;
    logic [15:0]   hdr_reg;
    logic          hdr_ninc;

    logic          slot_push, slot_pop, slot_load;
    logic          slot_full;
    logic [AW-1:0] slot_addr;

    cmdfe_decode #(.AW(AW)) u_decode (
        .word    (mem_rdata),
        .kind    (kind),
        .target  (target),
        .count   (hdr_count),
        .reg_ofs (hdr_reg),
        .ninc    (hdr_ninc)
    );

    cmdfe_clip #(.AW(AW), .CW(CW)) u_clip (
        .count     (hdr_count),
        .get_ptr   (get_q),
        .put_ptr   (put_q),
        .count_eff (eff_count)
    );

    cmdfe_retslot #(.AW(AW)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (slot_push),
        .push_addr  (get_q + STEP),
        .pop        (slot_pop),
        .load       (slot_load),
        .load_valid (rcv_ret_valid),
        .load_addr  (rcv_ret_addr),
        .full       (slot_full),
        .addr       (slot_addr)
    );

    // Next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        status_d  = status_q;
        get_d     = get_q;
        ptr_d     = ptr_q;
        rem_d     = rem_q;
        reg_d     = reg_q;
        ninc_d    = ninc_q;
        val_d     = val_q;
        loc_d     = loc_q;
        valid_d   = valid_q;
        err_d     = 1'b0;
        rd_en     = 1'b0;
        rd_addr   = get_q;
        slot_push = 1'b0;
        slot_pop  = 1'b0;
        slot_load = 1'b0;

        unique case (state_q)
            S_IDLE: begin
                if (get_q == put_q) begin
                    if (status_q == FS_RUNNING) status_d = FS_EMPTY;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = get_q;
                    state_d = S_DECODE;
                end
            end
            S_DECODE: begin
                state_d = S_IDLE;
                unique case (kind)
                    WK_JUMP_NARROW, WK_JUMP_WIDE: begin
                        get_d = target;
                        if (target == get_q) status_d = FS_SPIN;
                    end
                    WK_CALL: begin
                        if (slot_full) begin
                            get_d    = slot_addr;
                            slot_pop = 1'b1;
                        end else begin
                            get_d     = target;
                            slot_push = 1'b1;
                        end
                    end
                    WK_RETURN: begin
                        if (slot_full) begin
                            get_d    = slot_addr;
                            slot_pop = 1'b1;
                        end else begin
                            get_d = put_q;
                        end
                    end
                    WK_NOP: begin
                        get_d = get_q + STEP;
                        if (status_q == FS_RUNNING) status_d = FS_NOP;
                    end
                    WK_ILLEGAL: begin
                        get_d     = rcv_get;
                        slot_load = 1'b1;
                        err_d     = 1'b1;
                    end
                    WK_METHOD: begin
                        status_d = FS_RUNNING;
                        if (eff_count == '0) begin
                            get_d = get_q + STEP;
                        end else begin
                            rem_d   = eff_count;
                            reg_d   = hdr_reg;
                            ninc_d  = hdr_ninc;
                            ptr_d   = get_q + STEP;
                            rd_en   = 1'b1;
                            rd_addr = get_q + STEP;
                            state_d = S_ARGWAIT;
                        end
                    end
                    default: state_d = S_IDLE;
                endcase
            end
            S_ARGWAIT: begin
                val_d   = mem_rdata;
                loc_d   = ptr_q;
                valid_d = 1'b1;
                state_d = S_PRESENT;
            end
            S_PRESENT: begin
                if (cmd_ready) begin
                    valid_d = 1'b0;
                    if (rem_q == CW'(1)) begin
                        get_d   = ptr_q + STEP;
                        state_d = S_IDLE;
                    end else begin
                        rem_d   = rem_q - CW'(1);
                        reg_d   = reg_q + (ninc_q ? 16'd0 : 16'd4);
                        ptr_d   = ptr_q + STEP;
                        rd_en   = 1'b1;
                        rd_addr = ptr_q + STEP;
                        state_d = S_ARGWAIT;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase

        // Host redirect wins over everything fetched so far
        if (get_wr) begin
            get_d     = get_data;
            valid_d   = 1'b0;
            state_d   = S_IDLE;
            status_d  = status_q;
            err_d     = 1'b0;
            rd_en     = 1'b0;
            slot_push = 1'b0;
            slot_pop  = 1'b0;
            slot_load = 1'b0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= FS_EMPTY;
            get_q    <= '0;
            put_q    <= '0;
            ptr_q    <= '0;
            rem_q    <= '0;
            reg_q    <= '0;
            ninc_q   <= 1'b0;
            val_q    <= '0;
            loc_q    <= '0;
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            get_q    <= get_d;
            if (put_wr) put_q <= put_data;
            ptr_q    <= ptr_d;
            rem_q    <= rem_d;
            reg_q    <= reg_d;
            ninc_q   <= ninc_d;
            val_q    <= val_d;
            loc_q    <= loc_d;
            valid_q  <= valid_d;
            err_q    <= err_d;
        end
    end

    assign mem_rd_en = rd_en;
    assign mem_addr  = rd_addr;
    assign cmd_valid = valid_q;
    assign cmd_reg   = reg_q;
    assign cmd_value = val_q;
    assign cmd_loc   = loc_q;
    assign get_ptr   = get_q;
    assign fe_err    = err_q;
    assign fe_status = status_q;
endmodule

// File: rtl/cmdfe_chk.sv
`timescale 1ns/1ps
module cmdfe_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] get_ptr,
    input logic [AW-1:0] put_ptr,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [15:0]   cmd_reg,
    input logic [31:0]   cmd_value,
    input logic [AW-1:0] cmd_loc,
    input logic          get_wr,
    input logic [AW-1:0] get_data,
    input logic          fe_err
);
    // R1: a header fetch at get never happens on an empty ring
    a_r1_no_fetch_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_addr == get_ptr) |-> (get_ptr != put_ptr));

    // R5: a pending triple is held unchanged
    a_r5_hold_triple: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !get_wr) |=>
        (cmd_valid && $stable(cmd_reg) && $stable(cmd_value) && $stable(cmd_loc)));

    // R5: get does not move while a triple waits
    a_r5_get_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !get_wr) |=> $stable(get_ptr));

    // R9: the error is a single-cycle pulse
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fe_err |=> !fe_err);

    // R12: a host get write redirects and drops pending output
    a_r12_get_flush: assert property (@(posedge clk) disable iff (!rst_n)
        get_wr |=> (!cmd_valid && get_ptr == $past(get_data)));
endmodule

bind cmdfe_top cmdfe_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .get_ptr   (get_ptr),
    .put_ptr   (put_q),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_reg   (cmd_reg),
    .cmd_value (cmd_value),
    .cmd_loc   (cmd_loc),
    .get_wr    (get_wr),
    .get_data  (get_data),
    .fe_err    (fe_err)
);

// File: tb/cmdfe_top_test.sv
`timescale 1ns/1ps
module cmdfe_top_test;
    localparam int AW = 16;
    localparam int RCV_GET = 32'h100;
    localparam int RCV_RA  = 32'h110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          put_wr = 1'b0;
    logic [AW-1:0] put_data = '0;
    logic          get_wr = 1'b0;
    logic [AW-1:0] get_data = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [15:0]   cmd_reg;
    logic [31:0]   cmd_value;
    logic [AW-1:0] cmd_loc;
    logic [AW-1:0] get_ptr;
    logic          fe_err;
    logic [1:0]    fe_status;

    logic [31:0] mem [256];

    int checks = 0, fails = 0;
    int hs_cnt = 0, err_seen = 0;
    bit rnd_mode = 0, done = 0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R2";

    int eq_reg[$], eq_val[$], eq_loc[$];
    int m_get = 0, m_ra = 0, m_st = 1, m_errs = 0;
    bit m_rv = 0;

    always #2.5 clk = ~clk;

    cmdfe_top #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .put_wr(put_wr), .put_data(put_data), .get_wr(get_wr), .get_data(get_data),
        .rcv_get(AW'(RCV_GET)), .rcv_ret_valid(1'b1), .rcv_ret_addr(AW'(RCV_RA)),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_reg(cmd_reg),
        .cmd_value(cmd_value), .cmd_loc(cmd_loc), .get_ptr(get_ptr),
        .fe_err(fe_err), .fe_status(fe_status)
    );

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[9:2]];

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready = rnd_mode ? lfsr[0] : 1'b1;
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every accepted triple against the model queue
    always @(negedge clk) begin
        if (rst_n && fe_err) err_seen++;
        if (rst_n && cmd_valid && cmd_ready) begin
            hs_cnt++;
            checks++;
            if (eq_reg.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected triple actual=%0h/%0h/%0h expected=none",
                         cur_tag, cmd_reg, cmd_value, cmd_loc);
            end else begin
                int er, ev, el;
                er = eq_reg.pop_front(); ev = eq_val.pop_front(); el = eq_loc.pop_front();
                if (int'(cmd_reg) != er || cmd_value != ev || int'(cmd_loc) != el) begin
                    fails++;
                    $display("FAIL %s triple actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                             cur_tag, cmd_reg, cmd_value, cmd_loc, er, ev, el);
                end
            end
        end
    end

    function automatic void wr(int a, int w);
        mem[(a >> 2) & 255] = w;
    endfunction

    // Behavioural walker of the command ring
    task automatic model_run(int p);
        for (int s = 0; s < 200; s++) begin
            int w, t;
            if (m_get == p) begin
                if (m_st == 0) m_st = 1;
                break;
            end
            w = mem[(m_get >> 2) & 255];
            if ((w & 32'hE0000003) == 32'h20000000 || (w & 3) == 1) begin
                t = ((w & 32'hE0000003) == 32'h20000000) ? (w & 32'h1FFFFFFC) : (w & 32'hFFFFFFFC);
                t = t & 32'hFFFF;
                if (t == m_get) begin m_st = 3; break; end
                m_get = t;
            end else if (w == 32'h00020000) begin
                if (m_rv) begin m_get = m_ra; m_rv = 0; end
                else m_get = p;
            end else if ((w & 3) == 2) begin
                if (m_rv) begin m_get = m_ra; m_rv = 0; end
                else begin m_ra = (m_get + 4) & 32'hFFFF; m_rv = 1; m_get = w & 32'hFFFC; end
            end else if ((w & 3) == 3) begin
                m_get = RCV_GET; m_rv = 1; m_ra = RCV_RA; m_errs++;
            end else if ((w & 32'hBFFF0003) == 0) begin
                m_get = (m_get + 4) & 32'hFFFF;
                if (m_st == 0) m_st = 2;
            end else begin
                int cnt, base, avail;
                m_st = 0;
                cnt = (w >> 18) & 32'h7FF;
                avail = (p - m_get) & 32'hFFFF;
                if (cnt * 4 + 4 > avail) cnt = avail / 4 - 1;
                base = w & 32'hFFFC;
                for (int i = 0; i < cnt; i++) begin
                    eq_reg.push_back(((w >> 30) & 1) ? base : ((base + 4 * i) & 32'hFFFF));
                    eq_val.push_back(mem[((m_get + 4 + 4 * i) >> 2) & 255]);
                    eq_loc.push_back((m_get + 4 + 4 * i) & 32'hFFFF);
                end
                m_get = (m_get + 4 + 4 * cnt) & 32'hFFFF;
            end
        end
    endtask

    task automatic set_put(int p);
        @(posedge clk); #1;
        put_wr = 1'b1; put_data = AW'(p);
        @(posedge clk); #1;
        put_wr = 1'b0;
    endtask

    task automatic end_checks(string tag);
        chk({tag, " all triples delivered"}, eq_reg.size(), 0);
        chk({tag, " get"}, int'(get_ptr), m_get);
        chk({tag, " status"}, int'(fe_status), m_st);
        chk({tag, " errors"}, err_seen, m_errs);
    endtask

    task automatic run_case(string tag, int p);
        cur_tag = tag;
        model_run(p);
        set_put(p);
        repeat (150) @(negedge clk);
        end_checks(tag);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and no fetch on an empty ring
        chk("R1 reset valid", int'(cmd_valid), 0);
        chk("R1 reset get", int'(get_ptr), 0);
        chk("R1 reset status", int'(fe_status), 1);
        chk("R1 reset err", int'(fe_err), 0);
        repeat (3) @(negedge clk);
        chk("R1 no fetch when empty", int'(mem_rd_en), 0);

        // R2 R3: incrementing packet of three
        wr(32'h000, 32'h000C0100); wr(32'h004, 32'h11111111);
        wr(32'h008, 32'h22222222); wr(32'h00C, 32'h33333333);
        run_case("R2", 32'h010);

        // R3 R5 R10: non-increment packet under random backpressure, then a no-op
        wr(32'h010, 32'h40080200); wr(32'h014, 32'hA5A5A5A5);
        wr(32'h018, 32'h5A5A5A5A); wr(32'h01C, 32'h00000000);
        rnd_mode = 1;
        run_case("R3", 32'h020);
        rnd_mode = 0;
        chk("R10 nop-idle status", int'(fe_status), 2);

        // R4: count 5 clipped to 2
        wr(32'h020, 32'h00140300); wr(32'h024, 32'h44444444); wr(32'h028, 32'h55555555);
        run_case("R4", 32'h02C);

        // R6: narrow jump with high bits, then wide jump with high bits
        wr(32'h02C, 32'h30000080);
        wr(32'h080, 32'h00040040); wr(32'h084, 32'h66666666);
        wr(32'h088, 32'hFFFF00A1);
        wr(32'h0A0, 32'h00040044); wr(32'h0A4, 32'h77777777);
        run_case("R6", 32'h0A8);

        // R7: call and matching return
        wr(32'h0A8, 32'h000000C2);
        wr(32'h0C0, 32'h00040050); wr(32'h0C4, 32'h88888888); wr(32'h0C8, 32'h00020000);
        wr(32'h0AC, 32'h00040054); wr(32'h0B0, 32'h99999999);
        run_case("R7", 32'h0B4);

        // R8: nested call aborts, stray return discards to put
        wr(32'h0B4, 32'h000000D2); wr(32'h0D0, 32'h000000E2);
        wr(32'h0B8, 32'h00020000);
        wr(32'h0E0, 32'h000C0400);
        run_case("R8", 32'h0F0);

        // R9: illegal word, restore pointer and slot, then return via restored slot
        wr(32'h0F0, 32'h00000003);
        wr(32'h100, 32'h00020000);
        wr(32'h110, 32'h00040060); wr(32'h114, 32'hBBBBBBBB);
        run_case("R9", 32'h118);

        // R11: no-op then jump to self
        wr(32'h118, 32'h00000000); wr(32'h11C, 32'h2000011C);
        run_case("R11", 32'h140);
        chk("R11 spinning", int'(fe_status), 3);

        // R12: redirect to put breaks the spin; status is left alone
        @(posedge clk); #1;
        get_wr = 1'b1; get_data = AW'(32'h140);
        @(posedge clk); #1;
        get_wr = 1'b0;
        m_get = 32'h140;
        repeat (5) @(negedge clk);
        chk("R12 get after redirect", int'(get_ptr), 32'h140);
        chk("R11 spin kept on redirect", int'(fe_status), 3);

        // R12: get write in the cycle the third triple is accepted
        cur_tag = "R12";
        wr(32'h140, 32'h00180070);
        for (int i = 0; i < 6; i++) wr(32'h144 + 4 * i, 32'hC0DE0000 + i);
        model_run(32'h15C);
        while (eq_reg.size() > 3) begin
            void'(eq_reg.pop_back()); void'(eq_val.pop_back()); void'(eq_loc.pop_back());
        end
        m_get = 32'h15C;
        hs_cnt = 0;
        set_put(32'h15C);
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #1;
            if (cmd_valid && hs_cnt == 2) begin
                get_wr = 1'b1; get_data = AW'(32'h15C);
                @(posedge clk); #1;
                get_wr = 1'b0;
                break;
            end
        end
        repeat (40) @(negedge clk);
        chk("R12 delivered count", hs_cnt, 3);
        end_checks("R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule